// File: doc/BRIEF.md
# CAN Transmit Slot Manager

This block holds the outgoing messages of a CAN controller in three slots. For each slot it tracks whether the slot is free, whether an attempt has finished, and whether that attempt succeeded. The host loads a free slot through a small write port. It writes a length word, two data words and an identifier word. Setting bit 0 of the identifier word queues the slot for sending.

On the bus side the block offers one pending slot at a time to a frame transmitter, which is not part of this block. The transmitter takes the offered slot with a grant pulse. It later ends the attempt with a done pulse and a success bit.

Which pending slot is offered depends on a configuration input. In request-order mode the slots go out in the order they were queued. In priority mode the slot with the numerically lowest identifier goes first. The host can abort any slot. It clears the completion flags with a write-one-to-clear strobe. A shared interrupt line, when enabled, is high while any completion flag is set. In time-triggered mode, a slot with length code 8 has its last two data bytes replaced by a running 16-bit time value.

Top module: `txslot_mgr`

## Requirements
- R1: After reset, all three slots report empty, no completion flag and no ok flag are set, no slot is offered, and the interrupt line is low.
- R2: A write of the identifier word (field code 0) with bit 0 set, to an empty slot, clears that slot's empty, completion and ok flags at the next clock edge. The slot is then pending. The identifier is bits 31:1 of the word: RTR at bit 1, IDE at bit 2, a standard id at bits 31:21, an extended id at bits 31:3.
- R3: Writes to any field of a slot that is not empty are ignored. The other field codes are 1 for the control word (length code in bits 3:0), 2 for data bytes 0..3 and 3 for data bytes 4..7.
- R4: A done pulse with the success bit set for the in-flight slot sets its completion, ok and empty flags together.
- R5: A failed done for the in-flight slot returns it to pending with all flags clear when the retransmission-disable input is low. When that input is high, the failure completes the slot at once with completion and empty set and ok clear.
- R6: An abort of a pending slot completes it at the next edge as failed: completion and empty set, ok clear. An abort of the in-flight slot takes effect when the attempt ends: success still reports success, and failure reports failed with no retry. An abort of an empty slot changes nothing.
- R7: A 1 on a slot's clear strobe clears its completion flag. The interrupt output equals the interrupt enable ANDed with the OR of all completion flags.
- R8: With request order selected, the offered slot is the pending slot that was queued earliest. A slot requeued after a failed attempt keeps its original place.
- R9: With priority order selected, the offered slot is the pending slot whose identifier bits 31:1 are numerically lowest. Ties go to the lower slot number.
- R10: The offered data is 64 bits with byte n at bits 8n+7:8n, so each data word is packed little-endian. When time-triggered mode is on and the length code is 8, bits 63:48 carry the time input instead of bytes 6 and 7.
- R11: At most one slot is in flight. No slot is offered while one is in flight, and an offered slot is always pending. While a slot is in flight, the slot index and the id, length and data outputs show that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_en_i | input | 1 | Host write strobe |
| hw_slot_i | input | 2 | Target slot of the host write |
| hw_field_i | input | 2 | Field code: 0 id, 1 control, 2 data low, 3 data high |
| hw_data_i | input | 32 | Host write data |
| abort_i | input | 3 | Per-slot abort request pulse |
| clr_cmp_i | input | 3 | Per-slot write-one-to-clear of the completion flag |
| fifo_order_i | input | 1 | 1: request order, 0: identifier priority |
| no_retry_i | input | 1 | Complete a failed attempt instead of requeuing it |
| time_trig_i | input | 1 | Time-triggered mode |
| tme_ie_i | input | 1 | Completion interrupt enable |
| time_i | input | 16 | Running time value |
| tx_grant_i | input | 1 | Transmitter takes the offered slot |
| tx_done_i | input | 1 | Transmitter ends the attempt of the in-flight slot |
| tx_ok_i | input | 1 | Attempt result qualifying tx_done_i |
| empty_o | output | 3 | Per-slot empty flag |
| cmp_o | output | 3 | Per-slot completion flag |
| ok_o | output | 3 | Per-slot success flag |
| irq_o | output | 1 | Completion interrupt |
| tx_req_o | output | 1 | A pending slot is offered |
| tx_slot_o | output | 2 | Offered or in-flight slot |
| tx_id_o | output | 32 | Identifier word of that slot, bit 0 zero |
| tx_dlc_o | output | 4 | Length code of that slot |
| tx_data_o | output | 64 | Data bytes of that slot |

## Verification
Slot flags are registers. A write, abort, clear, grant or done applied before a clock edge shows on the flag outputs right after that edge. The bench drives each stimulus half a cycle before the edge and compares half a cycle after it. The offer outputs (tx_req_o, tx_slot_o, id, length and data) are combinational from slot state and the order and time inputs. They are checked in the same sample as the flags and reflect the state just written. The irq_o output follows the completion flags without an extra stage. A reference model in the bench steps once per edge, and every output is compared against it in every cycle, with directed checks of literal values at the corner cases.

// File: rtl/txslot_pkg.sv
package txslot_pkg;
  localparam int WORD_W   = 32;
  localparam int KEY_W    = WORD_W - 1;
  localparam int DLC_W    = 4;
  localparam int TS_W     = 16;
  localparam int FULL_DLC = 8;

  typedef enum logic [1:0] {
    FLD_ID   = 2'd0,
    FLD_CTRL = 2'd1,
    FLD_DLO  = 2'd2,
    FLD_DHI  = 2'd3
  } fld_e;

  typedef enum logic [1:0] {
    SL_EMPTY = 2'd0,
    SL_PEND  = 2'd1,
    SL_BUSY  = 2'd2
  } slot_st_e;
endpackage

// File: rtl/txslot_entry.sv
module txslot_entry
  import txslot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  fld_e              field_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              abort_i,
  input  logic              clr_i,
  input  logic              grant_i,
  input  logic              done_i,
  input  logic              ok_i,
  input  logic              no_retry_i,
  output logic [KEY_W-1:0]  id_o,
  output logic [DLC_W-1:0]  dlc_o,
  output logic [WORD_W-1:0] dlo_o,
  output logic [WORD_W-1:0] dhi_o,
  output logic              pend_o,
  output logic              busy_o,
  output logic              empty_o,
  output logic              cmp_o,
  output logic              ok_flag_o,
  output logic              req_o
);
  slot_st_e          st_q;
  logic [KEY_W-1:0]  id_q;
  logic [DLC_W-1:0]  dlc_q;
  logic [WORD_W-1:0] dlo_q, dhi_q;
  logic              cmp_q, ok_q, abt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SL_EMPTY;
      id_q  <= '0;
      dlc_q <= '0;
      dlo_q <= '0;
      dhi_q <= '0;
      cmp_q <= 1'b0;
      ok_q  <= 1'b0;
      abt_q <= 1'b0;
    end else begin
      if (clr_i) cmp_q <= 1'b0;
      case (st_q)
        SL_EMPTY: begin
          if (wr_i) begin
            case (field_i)
              FLD_ID: begin
                id_q <= data_i[WORD_W-1:1];
                if (data_i[0]) begin
                  st_q  <= SL_PEND;
                  cmp_q <= 1'b0;
                  ok_q  <= 1'b0;
                  abt_q <= 1'b0;
                end
              end
              FLD_CTRL: dlc_q <= data_i[DLC_W-1:0];
              FLD_DLO:  dlo_q <= data_i;
              default:  dhi_q <= data_i;
            endcase
          end
        end
        SL_PEND: begin
          if (grant_i) begin
            st_q  <= SL_BUSY;
            abt_q <= abort_i;
          end else if (abort_i) begin
            st_q  <= SL_EMPTY;
            cmp_q <= 1'b1;
            ok_q  <= 1'b0;
          end
        end
        SL_BUSY: begin
          if (abort_i) abt_q <= 1'b1;
          if (done_i) begin
            if (ok_i) begin
              st_q  <= SL_EMPTY;
              cmp_q <= 1'b1;
              ok_q  <= 1'b1;
            end else if (no_retry_i || abt_q || abort_i) begin
              st_q  <= SL_EMPTY;
              cmp_q <= 1'b1;
              ok_q  <= 1'b0;
            end else begin
              st_q <= SL_PEND;
            end
          end
        end
        default: st_q <= SL_EMPTY;
      endcase
    end
  end

  assign req_o     = wr_i && (field_i == FLD_ID) && data_i[0] && (st_q == SL_EMPTY);
  assign id_o      = id_q;
  assign dlc_o     = dlc_q;
  assign dlo_o     = dlo_q;
  assign dhi_o     = dhi_q;
  assign pend_o    = (st_q == SL_PEND);
  assign busy_o    = (st_q == SL_BUSY);
  assign empty_o   = (st_q == SL_EMPTY);
  assign cmp_o     = cmp_q;
  assign ok_flag_o = ok_q;
endmodule

// File: rtl/txslot_arb.sv
module txslot_arb
  import txslot_pkg::*;
#(
  parameter  int NSLOT = 3,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NSLOT-1:0]            pend_i,
  input  logic [NSLOT-1:0][KEY_W-1:0] key_i,
  input  logic [NSLOT-1:0]            req_set_i,
  input  logic                        fifo_i,
  output logic [SW-1:0]               sel_o,
  output logic                        valid_o
);
  // older_q[i][j]: slot i was queued before slot j
  logic [NSLOT-1:0][NSLOT-1:0] older_q;
  logic [NSLOT-1:0]            win_fifo, win_pri, win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSLOT; i++)
        for (int j = 0; j < NSLOT; j++)
          older_q[i][j] <= 1'(i < j);
    end else begin
      for (int i = 0; i < NSLOT; i++)
        for (int j = 0; j < NSLOT; j++)
          if (i != j) begin
            if (req_set_i[i])      older_q[i][j] <= 1'b0;
            else if (req_set_i[j]) older_q[i][j] <= 1'b1;
          end
    end
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      win_fifo[i] = pend_i[i];
      win_pri[i]  = pend_i[i];
      for (int j = 0; j < NSLOT; j++) begin
        if (j != i && pend_i[j]) begin
          if (!older_q[i][j]) win_fifo[i] = 1'b0;
          if ((key_i[j] < key_i[i]) || ((key_i[j] == key_i[i]) && (j < i)))
            win_pri[i] = 1'b0;
        end
      end
    end
  end

  assign win = fifo_i ? win_fifo : win_pri;

  always_comb begin
    sel_o = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (win[i]) sel_o = SW'(i);
  end

  assign valid_o = |pend_i;
endmodule

// File: rtl/txslot_mgr.sv
module txslot_mgr
  import txslot_pkg::*;
#(
  parameter  int NSLOT = 3,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hw_en_i,
  input  logic [SW-1:0]       hw_slot_i,
  input  logic [1:0]          hw_field_i,
  input  logic [WORD_W-1:0]   hw_data_i,
  input  logic [NSLOT-1:0]    abort_i,
  input  logic [NSLOT-1:0]    clr_cmp_i,
  input  logic                fifo_order_i,
  input  logic                no_retry_i,
  input  logic                time_trig_i,
  input  logic                tme_ie_i,
  input  logic [TS_W-1:0]     time_i,
  input  logic                tx_grant_i,
  input  logic                tx_done_i,
  input  logic                tx_ok_i,
  output logic [NSLOT-1:0]    empty_o,
  output logic [NSLOT-1:0]    cmp_o,
  output logic [NSLOT-1:0]    ok_o,
  output logic                irq_o,
  output logic                tx_req_o,
  output logic [SW-1:0]       tx_slot_o,
  output logic [WORD_W-1:0]   tx_id_o,
  output logic [DLC_W-1:0]    tx_dlc_o,
  output logic [2*WORD_W-1:0] tx_data_o
);
  localparam int DATA_W = 2 * WORD_W;

  fld_e                        fld;
  logic [NSLOT-1:0][KEY_W-1:0]  id_q;
  logic [NSLOT-1:0][DLC_W-1:0]  dlc_q;
  logic [NSLOT-1:0][WORD_W-1:0] dlo_q, dhi_q;
  logic [NSLOT-1:0]            pend_vec, busy_vec, req_vec;
  logic [SW-1:0]               sel_w, busy_idx, cur;
  logic                        valid_w, offer;
  logic [DATA_W-1:0]           raw_data;

  assign fld = fld_e'(hw_field_i);

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    txslot_entry u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (hw_en_i && (hw_slot_i == SW'(k))),
      .field_i    (fld),
      .data_i     (hw_data_i),
      .abort_i    (abort_i[k]),
      .clr_i      (clr_cmp_i[k]),
      .grant_i    (tx_grant_i && offer && (sel_w == SW'(k))),
      .done_i     (tx_done_i && busy_vec[k]),
      .ok_i       (tx_ok_i),
      .no_retry_i (no_retry_i),
      .id_o       (id_q[k]),
      .dlc_o      (dlc_q[k]),
      .dlo_o      (dlo_q[k]),
      .dhi_o      (dhi_q[k]),
      .pend_o     (pend_vec[k]),
      .busy_o     (busy_vec[k]),
      .empty_o    (empty_o[k]),
      .cmp_o      (cmp_o[k]),
      .ok_flag_o  (ok_o[k]),
      .req_o      (req_vec[k])
    );
  end

  txslot_arb #(.NSLOT(NSLOT)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend_vec),
    .key_i     (id_q),
    .req_set_i (req_vec),
    .fifo_i    (fifo_order_i),
    .sel_o     (sel_w),
    .valid_o   (valid_w)
  );

  always_comb begin
    busy_idx = '0;
    for (int i = 0; i < NSLOT; i++)
      if (busy_vec[i]) busy_idx = SW'(i);
  end

  assign offer     = valid_w && !(|busy_vec);
  assign cur       = (|busy_vec) ? busy_idx : sel_w;
  assign tx_req_o  = offer;
  assign tx_slot_o = cur;
  assign tx_id_o   = {id_q[cur], 1'b0};
  assign tx_dlc_o  = dlc_q[cur];
  assign raw_data  = {dhi_q[cur], dlo_q[cur]};

  always_comb begin
    tx_data_o = raw_data;
    if (time_trig_i && (dlc_q[cur] == DLC_W'(FULL_DLC)))
      tx_data_o[DATA_W-1 -: TS_W] = time_i;
  end

  assign irq_o = tme_ie_i && (|cmp_o);
endmodule

// File: rtl/txslot_mgr_chk.sv
module txslot_mgr_chk #(
  parameter  int NSLOT = 3,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hw_en_i,
  input logic [SW-1:0]    hw_slot_i,
  input logic [1:0]       hw_field_i,
  input logic             hw_req_i,
  input logic [NSLOT-1:0] abort_i,
  input logic             no_retry_i,
  input logic             tx_grant_i,
  input logic             tx_done_i,
  input logic             tx_ok_i,
  input logic             tx_req_o,
  input logic [SW-1:0]    tx_slot_o,
  input logic [NSLOT-1:0] empty_o,
  input logic [NSLOT-1:0] cmp_o,
  input logic [NSLOT-1:0] ok_o,
  input logic [NSLOT-1:0] pend_vec,
  input logic [NSLOT-1:0] busy_vec
);
  a_r11_no_offer_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|busy_vec) |-> !tx_req_o);

  a_r11_single_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(busy_vec) <= 1);

  a_r11_offer_is_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> pend_vec[tx_slot_o]);

  a_r2_req_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_en_i && hw_field_i == 2'd0 && hw_req_i && (int'(hw_slot_i) < NSLOT) && empty_o[hw_slot_i])
    |=> !empty_o[$past(hw_slot_i)] && !cmp_o[$past(hw_slot_i)]);

  a_r4_success: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && tx_ok_i && (|busy_vec))
    |=> cmp_o[$past(tx_slot_o)] && ok_o[$past(tx_slot_o)] && empty_o[$past(tx_slot_o)]);

  a_r5_no_retry_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !tx_ok_i && no_retry_i && (|busy_vec))
    |=> cmp_o[$past(tx_slot_o)] && !ok_o[$past(tx_slot_o)] && empty_o[$past(tx_slot_o)]);

  for (genvar k = 0; k < NSLOT; k++) begin : g_abort
    a_r6_abort_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (abort_i[k] && pend_vec[k] && !(tx_grant_i && tx_req_o && tx_slot_o == SW'(k)))
      |=> cmp_o[k] && !ok_o[k] && empty_o[k]);
  end
endmodule

bind txslot_mgr txslot_mgr_chk #(.NSLOT(NSLOT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hw_en_i    (hw_en_i),
  .hw_slot_i  (hw_slot_i),
  .hw_field_i (hw_field_i),
  .hw_req_i   (hw_data_i[0]),
  .abort_i    (abort_i),
  .no_retry_i (no_retry_i),
  .tx_grant_i (tx_grant_i),
  .tx_done_i  (tx_done_i),
  .tx_ok_i    (tx_ok_i),
  .tx_req_o   (tx_req_o),
  .tx_slot_o  (tx_slot_o),
  .empty_o    (empty_o),
  .cmp_o      (cmp_o),
  .ok_o       (ok_o),
  .pend_vec   (pend_vec),
  .busy_vec   (busy_vec)
);

// File: tb/txslot_mgr_test.sv
module txslot_mgr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_en = 1'b0;
  logic [1:0]  hw_slot = '0, hw_field = '0;
  logic [31:0] hw_data = '0;
  logic [2:0]  abort_v = '0, clr_v = '0;
  logic        fifo = 1'b0, noretry = 1'b0, ttm = 1'b0, ie = 1'b1;
  logic [15:0] tmv = '0;
  logic        grant = 1'b0, done = 1'b0, okv = 1'b0;

  logic [2:0]  empty_o, cmp_o, ok_o;
  logic        irq_o, tx_req_o;
  logic [1:0]  tx_slot_o;
  logic [31:0] tx_id_o;
  logic [3:0]  tx_dlc_o;
  logic [63:0] tx_data_o;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  txslot_mgr uut (
    .clk_i(clk), .rst_ni(rst_n), .hw_en_i(hw_en), .hw_slot_i(hw_slot),
    .hw_field_i(hw_field), .hw_data_i(hw_data), .abort_i(abort_v), .clr_cmp_i(clr_v),
    .fifo_order_i(fifo), .no_retry_i(noretry), .time_trig_i(ttm), .tme_ie_i(ie),
    .time_i(tmv), .tx_grant_i(grant), .tx_done_i(done), .tx_ok_i(okv),
    .empty_o(empty_o), .cmp_o(cmp_o), .ok_o(ok_o), .irq_o(irq_o), .tx_req_o(tx_req_o),
    .tx_slot_o(tx_slot_o), .tx_id_o(tx_id_o), .tx_dlc_o(tx_dlc_o), .tx_data_o(tx_data_o)
  );

  // reference model: 0 empty, 1 pending, 2 in flight
  int          m_st[3];
  logic        m_cmp[3], m_ok[3], m_abt[3];
  logic [30:0] m_id[3];
  logic [3:0]  m_dlc[3];
  logic [31:0] m_dlo[3], m_dhi[3];
  int          m_stamp[3];
  int          m_seq = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int model_offer();
    int w;
    for (int k = 0; k < 3; k++) if (m_st[k] == 2) return -1;
    w = -1;
    for (int k = 0; k < 3; k++) begin
      if (m_st[k] != 1) continue;
      if (w < 0) w = k;
      else if (fifo ? (m_stamp[k] < m_stamp[w]) : (m_id[k] < m_id[w])) w = k;
    end
    return w;
  endfunction

  function automatic bit model_busy();
    for (int k = 0; k < 3; k++) if (m_st[k] == 2) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int model_cur();
    for (int k = 0; k < 3; k++) if (m_st[k] == 2) return k;
    return model_offer();
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      m_st[k] = 0; m_cmp[k] = 0; m_ok[k] = 0; m_abt[k] = 0;
      m_id[k] = '0; m_dlc[k] = '0; m_dlo[k] = '0; m_dhi[k] = '0; m_stamp[k] = k;
    end
    m_seq = 3;
  endtask

  task automatic compare_all();
    logic [2:0] e_em, e_cm, e_ok;
    logic [63:0] ed;
    int s, c;
    for (int k = 0; k < 3; k++) begin
      e_em[k] = (m_st[k] == 0); e_cm[k] = m_cmp[k]; e_ok[k] = m_ok[k];
    end
    chk("R2 empty flags", 64'(empty_o), 64'(e_em));
    chk("R4 complete flags", 64'(cmp_o), 64'(e_cm));
    chk("R5 ok flags", 64'(ok_o), 64'(e_ok));
    chk("R7 irq", 64'(irq_o), 64'(ie && (|e_cm)));
    s = model_offer();
    chk("R11 offer valid", 64'(tx_req_o), 64'(s >= 0));
    c = model_cur();
    if (c >= 0) begin
      chk(fifo ? "R8 offered slot" : "R9 offered slot", 64'(tx_slot_o), 64'(c));
      chk("R3 offered id", 64'(tx_id_o), 64'({m_id[c], 1'b0}));
      chk("R3 offered length", 64'(tx_dlc_o), 64'(m_dlc[c]));
      ed = {m_dhi[c], m_dlo[c]};
      if (ttm && m_dlc[c] == 4'd8) ed[63:48] = tmv;
      chk("R10 offered data", tx_data_o, ed);
    end
  endtask

  task automatic tick();
    int  s;
    bit  g, d;
    s = model_offer();
    for (int k = 0; k < 3; k++) begin
      g = grant && (s == k);
      d = done && (m_st[k] == 2);
      if (clr_v[k]) m_cmp[k] = 1'b0;
      case (m_st[k])
        0: if (hw_en && hw_slot == 2'(k)) begin
             case (hw_field)
               2'd0: begin
                 m_id[k] = hw_data[31:1];
                 if (hw_data[0]) begin
                   m_st[k] = 1; m_cmp[k] = 0; m_ok[k] = 0; m_abt[k] = 0;
                   m_stamp[k] = m_seq; m_seq++;
                 end
               end
               2'd1: m_dlc[k] = hw_data[3:0];
               2'd2: m_dlo[k] = hw_data;
               default: m_dhi[k] = hw_data;
             endcase
           end
        1: if (g) begin m_st[k] = 2; m_abt[k] = abort_v[k]; end
           else if (abort_v[k]) begin m_st[k] = 0; m_cmp[k] = 1; m_ok[k] = 0; end
        default: begin
          if (abort_v[k]) m_abt[k] = 1;
          if (d) begin
            if (okv) begin m_st[k] = 0; m_cmp[k] = 1; m_ok[k] = 1; end
            else if (noretry || m_abt[k]) begin m_st[k] = 0; m_cmp[k] = 1; m_ok[k] = 0; end
            else m_st[k] = 1;
          end
        end
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    hw_en = 0; abort_v = '0; clr_v = '0; grant = 0; done = 0; okv = 0;
    compare_all();
  endtask

  task automatic wr(int slot, int field, logic [31:0] data);
    hw_en = 1; hw_slot = 2'(slot); hw_field = 2'(field); hw_data = data;
    tick();
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty after reset", 64'(empty_o), 64'h7);
    chk("R1 complete after reset", 64'(cmp_o), 64'h0);
    chk("R1 ok after reset", 64'(ok_o), 64'h0);
    chk("R1 no offer after reset", 64'(tx_req_o), 64'h0);
    chk("R1 irq after reset", 64'(irq_o), 64'h0);

    // R2 load slot 0
    wr(0, 1, 32'd8);
    wr(0, 2, 32'h44332211);
    wr(0, 3, 32'h88776655);
    wr(0, 0, (32'h123 << 21) | 32'h1);
    chk("R2 empty clears on request", 64'(empty_o), 64'h6);
    chk("R2 offered id", 64'(tx_id_o), 64'(32'h123 << 21));

    // R3 write to pending slot ignored
    wr(0, 2, 32'hdeadbeef);
    chk("R3 ignored write", 64'(tx_data_o[31:0]), 64'h44332211);

    // R10 timestamp substitution
    ttm = 1; tmv = 16'hbeef;
    tick();
    chk("R10 time in bytes 6..7", 64'(tx_data_o[63:48]), 64'hbeef);
    chk("R10 low bytes kept", 64'(tx_data_o[47:0]), 64'h665544332211);
    ttm = 0;

    // R4 grant then success
    grant = 1; tick();
    chk("R11 no offer in flight", 64'(tx_req_o), 64'h0);
    done = 1; okv = 1; tick();
    chk("R4 success complete", 64'(cmp_o), 64'h1);
    chk("R4 success ok", 64'(ok_o), 64'h1);
    chk("R4 success empty", 64'(empty_o), 64'h7);
    chk("R7 irq on complete", 64'(irq_o), 64'h1);
    clr_v = 3'b001; tick();
    chk("R7 clear complete", 64'(cmp_o), 64'h0);
    chk("R7 irq drops", 64'(irq_o), 64'h0);

    // R9 / R8 ordering
    wr(1, 0, (32'h300 << 21) | 32'h1);
    wr(2, 0, (32'h100 << 21) | 32'h1);
    chk("R9 lowest id first", 64'(tx_slot_o), 64'h2);
    fifo = 1; tick();
    chk("R8 request order", 64'(tx_slot_o), 64'h1);

    // R5 retry then no-retry failure
    grant = 1; tick();
    done = 1; okv = 0; tick();
    chk("R5 requeued not empty", 64'(empty_o[1]), 64'h0);
    chk("R5 requeued not complete", 64'(cmp_o[1]), 64'h0);
    chk("R8 requeued keeps place", 64'(tx_slot_o), 64'h1);
    noretry = 1;
    grant = 1; tick();
    done = 1; okv = 0; tick();
    chk("R5 failed complete", 64'(cmp_o[1]), 64'h1);
    chk("R5 failed ok clear", 64'(ok_o[1]), 64'h0);
    chk("R5 failed empty", 64'(empty_o[1]), 64'h1);
    noretry = 0;

    // R6 aborts
    abort_v = 3'b100; tick();
    chk("R6 abort pending", 64'({cmp_o[2], ok_o[2], empty_o[2]}), 64'b101);
    abort_v = 3'b001; tick();
    chk("R6 abort empty no effect", 64'({cmp_o[0], ok_o[0], empty_o[0]}), 64'b011);
    wr(0, 0, (32'h055 << 21) | 32'h1);
    grant = 1; tick();
    abort_v = 3'b001; tick();
    chk("R6 abort in flight waits", 64'(empty_o[0]), 64'h0);
    done = 1; okv = 1; tick();
    chk("R6 abort then success", 64'({cmp_o[0], ok_o[0]}), 64'b11);

    // constrained random phase
    for (int it = 0; it < 3000; it++) begin
      if ($urandom % 16 < 5) begin
        hw_en = 1; hw_slot = 2'($urandom % 4); hw_field = 2'($urandom % 4);
        hw_data = $urandom;
        if (hw_field == 2'd0)
          hw_data = (($urandom % 8) << ((($urandom % 2) != 0) ? 21 : 3))
                  | (($urandom % 4) << 1) | 32'(($urandom % 3) != 0);
        else if (hw_field == 2'd1 && ($urandom % 2) != 0)
          hw_data = 32'd8;
      end
      if ($urandom % 20 == 0) abort_v = 3'($urandom);
      if ($urandom % 10 == 0) clr_v = 3'($urandom);
      if ($urandom % 50 == 0) fifo = ~fifo;
      if ($urandom % 50 == 0) noretry = ~noretry;
      if ($urandom % 50 == 0) ttm = ~ttm;
      if ($urandom % 50 == 0) ie = ~ie;
      tmv = 16'($urandom);
      if (model_offer() >= 0 && ($urandom % 2) != 0) grant = 1;
      if (model_busy() && ($urandom % 3) == 0) begin
        done = 1; okv = 1'($urandom % 2);
      end
      tick();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule